// File: doc/BRIEF.md
# Huffman Encoder and Bit Packer

This block compresses a stream of byte-wide symbols for a serial link. Each accepted symbol selects one entry of a symbol table that can be loaded at run time. The entry holds a prefix-free code of up to 16 bits and its length. The code bits are appended to a pending-bit accumulator. Whole bytes leave through a valid/ready output as soon as eight bits are pending, and a code may straddle a byte boundary.

Software loads the table through a simple write port, and a clear strobe invalidates the whole table before it is reloaded. At the end of a message, a flush command returns the leftover partial byte together with the number of meaningful bits in it, and empties the accumulator. A symbol whose table entry has an unusable length is dropped, and an error pulse is raised.

Top module: `huff_packer`

## Requirements
- R1: A write with `tbl_we` high stores `tbl_code` and `tbl_len` at index `tbl_addr`. Symbols accepted from the following cycle onward use the new entry.
- R2: `tbl_clear` sets the length of every entry to 0 at the next edge. A write in the same cycle still takes effect for its own index.
- R3: An entry is valid when its length L is between 1 and 16. Its code is `code[L-1:0]`, and `code[L-1]` is sent first. Code bits above L are ignored.
- R4: The first pending bit appears at bit 7 of `out_data`, and later bits follow toward bit 0. A code that crosses a byte boundary completes the current byte with its leading bits and starts the next byte with the rest.
- R5: `out_valid` is high exactly while eight or more bits are pending. `out_data` stays stable until `out_ready` is seen, and at most one byte leaves per cycle.
- R6: `sym_ready` is low whenever `out_valid` is high or `flush_req` is high. It is high otherwise.
- R7: `enc_filled` pulses in the cycle after an accepted valid symbol has brought the pending count to eight or more.
- R8: An accepted symbol whose entry length is 0 or above 16 adds no bits, and `sym_err` pulses in the following cycle.
- R9: When `flush_req` is high and `out_valid` is low, the next cycle shows a one-cycle `flush_done`. In that cycle `flush_data` holds the pending bits from bit 7 down, with zeros below them, and `flush_count` holds how many bits are pending (0 to 7). The accumulator is then empty.
- R10: After reset, no bits are pending, every table entry has length 0, `out_valid`, `enc_filled`, `sym_err` and `flush_done` are low, and `sym_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_clear | input | 1 | Invalidate all table entries |
| tbl_addr | input | 8 | Entry index (symbol value) |
| tbl_code | input | 16 | Code bits, right-aligned |
| tbl_len | input | 5 | Code length in bits |
| sym_valid | input | 1 | Input symbol present |
| sym_ready | output | 1 | Input symbol accepted |
| sym_data | input | 8 | Input symbol |
| out_valid | output | 1 | Packed byte available |
| out_ready | input | 1 | Sink takes the byte |
| out_data | output | 8 | Packed byte, first bit in bit 7 |
| enc_filled | output | 1 | Last symbol completed a byte |
| sym_err | output | 1 | Last symbol had an invalid entry |
| flush_req | input | 1 | Request return of the partial byte |
| flush_done | output | 1 | Flush result valid |
| flush_data | output | 8 | Partial byte, left-aligned |
| flush_count | output | 3 | Valid bits in flush_data |

## Verification
The assertions assume three things about the environment. A flush request is held until `flush_done` appears. Table writes are not aimed at the symbol being presented in the same cycle when that cycle's result matters. The sink may stall for any number of cycles. The stimulus drives all inputs half a cycle away from the sampling edge and keeps `flush_req` asserted through its wait. The randomised phases mix valid and invalid symbols with random backpressure, so that stalls, flushes with 0 to 7 pending bits, and codes crossing byte boundaries all occur together.

// File: rtl/huff_packer.sv
module huff_packer #(
  parameter int SYM_W  = 8,
  parameter int CODE_W = 16,
  parameter int LEN_W  = 5,
  parameter int OUT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tbl_we,
  input  logic                     tbl_clear,
  input  logic [SYM_W-1:0]         tbl_addr,
  input  logic [CODE_W-1:0]        tbl_code,
  input  logic [LEN_W-1:0]         tbl_len,
  input  logic                     sym_valid,
  output logic                     sym_ready,
  input  logic [SYM_W-1:0]         sym_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [OUT_W-1:0]         out_data,
  output logic                     enc_filled,
  output logic                     sym_err,
  input  logic                     flush_req,
  output logic                     flush_done,
  output logic [OUT_W-1:0]         flush_data,
  output logic [$clog2(OUT_W)-1:0] flush_count
);
  localparam int DEPTH = 1 << SYM_W;
  localparam int ACC_W = CODE_W + OUT_W - 1;
  localparam int CNT_W = $clog2(ACC_W + 1);
  localparam int FC_W  = $clog2(OUT_W);

  logic [CODE_W-1:0] code_mem [DEPTH];
  logic [LEN_W-1:0]  len_mem  [DEPTH];
  logic [ACC_W-1:0]  acc_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        code_mem[i] <= '0;
        len_mem[i]  <= '0;
      end
    end else begin
      if (tbl_clear)
        for (int i = 0; i < DEPTH; i++) len_mem[i] <= '0;
      if (tbl_we) begin
        code_mem[tbl_addr] <= tbl_code;
        len_mem[tbl_addr]  <= tbl_len;
      end
    end
  end

  logic [CODE_W-1:0] cur_code, code_m;
  logic [LEN_W-1:0]  cur_len;
  logic [LEN_W:0]    lsh;
  logic [ACC_W-1:0]  ins;
  logic [CNT_W-1:0]  sum;
  logic              len_ok, byte_rdy, sym_fire, out_fire, fl_fire;

  assign cur_code = code_mem[sym_data];
  assign cur_len  = len_mem[sym_data];
  assign len_ok   = (cur_len != '0) && (int'(cur_len) <= CODE_W);
  assign code_m   = cur_code & ~({CODE_W{1'b1}} << cur_len);
  assign lsh      = (LEN_W+1)'(CODE_W) - {1'b0, cur_len};
  assign ins      = ({code_m, {(OUT_W-1){1'b0}}} << lsh) >> cnt_q;
  assign sum      = cnt_q + CNT_W'(cur_len);

  assign byte_rdy  = cnt_q >= CNT_W'(OUT_W);
  assign sym_ready = !byte_rdy && !flush_req;
  assign out_valid = byte_rdy;
  assign out_data  = acc_q[ACC_W-1 -: OUT_W];
  assign sym_fire  = sym_valid && sym_ready;
  assign out_fire  = out_valid && out_ready;
  assign fl_fire   = flush_req && !byte_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q       <= '0;
      cnt_q       <= '0;
      enc_filled  <= 1'b0;
      sym_err     <= 1'b0;
      flush_done  <= 1'b0;
      flush_data  <= '0;
      flush_count <= '0;
    end else begin
      enc_filled <= 1'b0;
      sym_err    <= 1'b0;
      flush_done <= 1'b0;
      if (out_fire) begin
        acc_q <= acc_q << OUT_W;
        cnt_q <= cnt_q - CNT_W'(OUT_W);
      end else if (fl_fire) begin
        acc_q       <= '0;
        cnt_q       <= '0;
        flush_done  <= 1'b1;
        flush_data  <= acc_q[ACC_W-1 -: OUT_W];
        flush_count <= cnt_q[FC_W-1:0];
      end else if (sym_fire) begin
        if (len_ok) begin
          acc_q      <= acc_q | ins;
          cnt_q      <= sum;
          enc_filled <= sum >= CNT_W'(OUT_W);
        end else begin
          sym_err <= 1'b1;
        end
      end
    end
  end

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_in_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !sym_ready);
  assert_filled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enc_filled |-> out_valid);
  assert_bad_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && sym_ready && !len_ok |=> sym_err && $stable(cnt_q));
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !out_valid |=> flush_done && cnt_q == '0);
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ACC_W));
endmodule

// File: tb/huff_packer_tb.sv
`timescale 1ns/1ps
module huff_packer_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, tbl_we, tbl_clear, sym_valid, out_ready, flush_req;
  logic [7:0] tbl_addr, sym_data;
  logic [15:0] tbl_code;
  logic [4:0] tbl_len;
  logic sym_ready, out_valid, enc_filled, sym_err, flush_done;
  logic [7:0] out_data, flush_data;
  logic [2:0] flush_count;

  huff_packer u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_clear(tbl_clear),
    .tbl_addr(tbl_addr), .tbl_code(tbl_code), .tbl_len(tbl_len),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .enc_filled(enc_filled), .sym_err(sym_err), .flush_req(flush_req),
    .flush_done(flush_done), .flush_data(flush_data), .flush_count(flush_count));

  bit q[$];
  logic [15:0] mcode [256];
  logic [4:0]  mlen  [256];
  int checks = 0, fails = 0;
  bit e_fill = 0, e_err = 0, e_fd = 0;
  logic [7:0] e_fdata = '0;
  int e_fcnt = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic cyc();
    int sz, L;
    logic [7:0] b;
    bit n_fill, n_err, n_fd;
    #1;
    sz = q.size();
    chk(sym_ready == (sz < 8 && !flush_req), "R6", "sym_ready", sym_ready, sz < 8 && !flush_req);
    chk(out_valid == (sz >= 8), "R5", "out_valid", out_valid, sz >= 8);
    if (sz >= 8) begin
      b = '0;
      for (int i = 0; i < 8; i++) b = {b[6:0], q[i]};
      chk(out_data == b, "R4", "out_data", out_data, b);
    end
    chk(enc_filled == e_fill, "R7", "enc_filled", enc_filled, e_fill);
    chk(sym_err == e_err, "R8", "sym_err", sym_err, e_err);
    chk(flush_done == e_fd, "R9", "flush_done", flush_done, e_fd);
    if (e_fd) begin
      chk(flush_data == e_fdata, "R9", "flush_data", flush_data, e_fdata);
      chk(int'(flush_count) == e_fcnt, "R9", "flush_count", flush_count, e_fcnt);
    end
    n_fill = 0; n_err = 0; n_fd = 0;
    if (out_ready && sz >= 8) begin
      for (int i = 0; i < 8; i++) void'(q.pop_front());
    end else if (flush_req && sz < 8) begin
      n_fd = 1; e_fcnt = sz; e_fdata = '0;
      for (int i = 0; i < sz; i++) e_fdata[7-i] = q[i];
      q.delete();
    end else if (sym_valid && sz < 8 && !flush_req) begin
      L = mlen[sym_data];
      if (L == 0 || L > 16) n_err = 1;
      else begin
        for (int i = L - 1; i >= 0; i--) q.push_back(mcode[sym_data][i]);
        n_fill = (sz + L) >= 8;
      end
    end
    if (tbl_clear) for (int i = 0; i < 256; i++) mlen[i] = '0;
    if (tbl_we) begin mcode[tbl_addr] = tbl_code; mlen[tbl_addr] = tbl_len; end
    @(posedge clk);
    @(negedge clk);
    e_fill = n_fill; e_err = n_err; e_fd = n_fd;
  endtask

  task automatic idle();
    tbl_we = 0; tbl_clear = 0; sym_valid = 0; flush_req = 0; out_ready = 1;
  endtask

  task automatic wr(int a, int c, int l);
    idle(); tbl_we = 1; tbl_addr = 8'(a); tbl_code = 16'(c); tbl_len = 5'(l); cyc();
    tbl_we = 0;
  endtask

  task automatic flush_all();
    idle(); flush_req = 1;
    while (!(q.size() < 8)) cyc();
    cyc(); flush_req = 0; cyc();
  endtask

  task automatic run(int n, int lo, int hi, int bad_pct, int rdy_pct);
    for (int k = 0; k < n; k++) begin
      idle();
      sym_valid = ($urandom % 100) < 80;
      sym_data = ($urandom % 100) < bad_pct ? 8'hF0 : 8'(lo + $urandom % (hi - lo + 1));
      out_ready = ($urandom % 100) < rdy_pct;
      cyc();
      if ($urandom % 40 == 0) flush_all();
    end
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mcode[i] = '0; mlen[i] = '0; end
    tbl_addr = '0; tbl_code = '0; tbl_len = '0; sym_data = '0;
    idle(); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();                       // R10: reset state
    sym_valid = 1; sym_data = 8'h61; cyc(); idle(); cyc();   // R10, R8: empty table
    // R1: example prefix-free table
    wr(8'h61, 16'h0001, 1); wr(8'h62, 16'h0001, 2); wr(8'h63, 16'h0000, 4);
    wr(8'h64, 16'h0001, 4); wr(8'h65, 16'h0002, 4); wr(8'h66, 16'h0003, 4);
    // R3: stray upper bits must be ignored
    wr(8'h67, 16'hFFF2, 3);
    for (int i = 0; i < 7; i++) begin
      idle(); sym_valid = 1; sym_data = 8'(8'h61 + i); cyc();
      while (!sym_ready) begin idle(); cyc(); end
    end
    idle(); cyc(); flush_all();
    flush_all();                 // R9: flush with nothing pending
    run(3000, 8'h61, 8'h67, 10, 60);
    // R4: long codes crossing byte boundaries
    for (int s = 0; s < 8; s++) wr(s, $urandom, 9 + s);
    wr(8, 16'hA5C3, 17);         // R8: length above 16
    run(3000, 0, 8, 5, 50);
    flush_all();
    // R2: clear with simultaneous write
    idle(); tbl_clear = 1; tbl_we = 1; tbl_addr = 8'h62; tbl_code = 16'h0005; tbl_len = 5'd3; cyc();
    idle(); sym_valid = 1; sym_data = 8'h61; cyc();   // R2: cleared entry errors
    sym_data = 8'h62; cyc();                          // R2: written entry survives
    idle(); cyc(); flush_all();
    run(500, 8'h61, 8'h62, 0, 30);
    flush_all();
    summary();
  end
endmodule